// File: doc/BRIEF.md
# Write-Through Data Cache with Store Buffer

This block sits between a processor load/store port and a word-wide memory that is much slower than the processor. It is a direct-mapped cache of 1024 one-word lines. A load that finds its line returns the word two clock edges after it is accepted. A load that misses holds the requester off, reads one word from memory, installs the word in the line and returns it. A memory read is not needed when a store still waiting in the buffer already holds that address.

Stores never wait for memory. Each accepted store goes into a small FIFO, and that FIFO writes to memory in the background, one entry per accepted memory write. If the store finds its line, the cached word is updated at the same time. If it misses, no line is allocated and the indexed line is made invalid, so the line cannot keep a stale word. The processor is held off only when the FIFO is full. The FIFO depth is a parameter and must be a power of two.

The processor port accepts one request at a time. A response is a single-cycle pulse, and only loads get one. The memory port carries reads and writes on one request channel. Read data comes back on a separate response strobe.

Top module: `wt_cache`

## Requirements
- R1: A byte address is split into a tag in bits 31..12, a line index in bits 11..2 and a byte offset in bits 1..0. Two addresses that differ only in the tag share one line and evict each other. Addresses with different indices do not disturb each other.
- R2: A load that hits (line valid and stored tag equal to the address tag) produces exactly one `cpu_rsp_valid` pulse, two rising edges after the accepting edge. The pulse carries the cached word, and no memory read is requested.
- R3: A load that misses and finds no pending store to its word requests a memory read (`mem_req_we`=0) and holds the request stable until `mem_req_ready`. It returns `mem_rsp_rdata` and installs that word with its tag, so that the next load of that address hits.
- R4: A store that hits overwrites the cached word. A later load of that address hits and returns the stored value.
- R5: A store that misses leaves the line contents unwritten and clears the line's valid bit. The next load of the address the line held before then misses.
- R6: Every accepted store reaches memory exactly once, in acceptance order, as one write handshake (`mem_req_we`=1) with the word address in bits 31..2 and bits 1..0 zero. A request that is not accepted keeps its address and kind on the next cycle.
- R7: `cpu_req_ready` is high whenever the cache is idle and the store buffer holds fewer than WB_DEPTH stores. With WB_DEPTH stores undrained it stays low until one drains, and the buffer never holds more than WB_DEPTH entries.
- R8: A missing load whose word matches pending stores takes the data of the youngest matching store. It requests no memory read, responds two edges after acceptance and installs the word in the line.
- R9: After reset every line is invalid, so the first load of any address misses. No response and no memory request is pending, and `cpu_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address of the access |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Cache can take a request this cycle |
| cpu_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_we | output | 1 | 1 = buffered store write, 0 = line read |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | DATA_W | Read data |

## Verification
The checks assume that the memory raises `mem_rsp_valid` only while a line read is outstanding, gives exactly one strobe per accepted read, and keeps reads and writes in the order it accepted them. The bench memory model follows these rules. It answers each accepted read after a fixed delay with the word it held at acceptance, and it applies writes in handshake order. The model lowers `mem_req_ready` only on a pseudo-random pattern, or for a whole phase when the bench wants the buffer to fill. Processor requests are sent only after `cpu_req_ready` has been seen high, and a new one is not sent until the previous load has answered.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_MREQ  = 2'd2,
    ST_MWAIT = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/wt_cache_store.sv
// Line storage: tag and word in an inferable RAM with one synchronous read
// port; valid bits in flops so that reset can clear them all at once.
module wt_cache_store #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20,
  parameter int DW    = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [DW-1:0]    wr_data,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);
  logic [TAG_W+DW-1:0] ram [LINES];
  logic [TAG_W+DW-1:0] rd_q;
  logic [LINES-1:0]    vbits;
  logic                rd_v_q;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= {wr_tag, wr_data};
    if (rd_en) rd_q <= ram[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits  <= '0;
      rd_v_q <= 1'b0;
    end else begin
      if (wr_en)  vbits[wr_idx]  <= 1'b1;
      if (inv_en) vbits[inv_idx] <= 1'b0;
      if (rd_en)  rd_v_q         <= vbits[rd_idx];
    end
  end

  assign rd_valid        = rd_v_q;
  assign {rd_tag, rd_data} = rd_q;
endmodule

// File: rtl/wt_cache_wbuf.sv
// Store FIFO with an associative search of the pending entries; the youngest
// matching entry supplies the forwarded word.
module wt_cache_wbuf #(
  parameter int AW    = 30,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [AW-1:0]    push_addr,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [AW-1:0]    head_addr,
  output logic [DW-1:0]    head_data,
  output logic             not_empty,
  output logic             full,
  output logic [CNT_W-1:0] count,
  input  logic [AW-1:0]    look_addr,
  output logic             fwd_hit,
  output logic [DW-1:0]    fwd_data
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      if (push && !pop)      count <= count + CNT_W'(1);
      else if (!push && pop) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  // match[g] refers to the entry g places behind the oldest one
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = (CNT_W'(g) < count) &&
                      (addr_q[rd_ptr + PTR_W'(g)] == look_addr);
  end

  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        fwd_hit  = 1'b1;
        fwd_data = data_q[rd_ptr + PTR_W'(i)];
      end
    end
  end

  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign not_empty = (count != '0);
  assign full      = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 10,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  localparam int OFF_W    = 2;
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam int WA_W     = ADDR_W - OFF_W;
  localparam int WB_CNT_W = $clog2(WB_DEPTH + 1);

  ctl_state_e state_q, state_d;

  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              wr_busy_q;

  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WA_W-1:0]   word_q;

  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;

  logic              wb_push, wb_pop, wb_not_empty, wb_full, fwd_hit;
  logic [WA_W-1:0]   wb_head_addr;
  logic [DATA_W-1:0] wb_head_data, fwd_data;
  logic [WB_CNT_W-1:0] wb_count;

  logic accept, look, hit, st_look, ld_look, ld_fwd, fill_mem, load_done;
  logic line_wr, line_inv, rd_sel;
  logic [DATA_W-1:0] load_data, line_wdata;

  assign idx_q  = req_addr_q[IDX_W+OFF_W-1:OFF_W];
  assign tag_q  = req_addr_q[ADDR_W-1:IDX_W+OFF_W];
  assign word_q = req_addr_q[ADDR_W-1:OFF_W];

  assign cpu_req_ready = (state_q == ST_IDLE) && !wb_full;
  assign accept        = cpu_req_valid && cpu_req_ready;

  assign look     = (state_q == ST_LOOK);
  assign hit      = look && line_valid && (line_tag == tag_q);
  assign st_look  = look && req_we_q;
  assign ld_look  = look && !req_we_q;
  assign ld_fwd   = ld_look && !hit && fwd_hit;
  assign fill_mem = (state_q == ST_MWAIT) && mem_rsp_valid;

  assign load_done = (ld_look && (hit || fwd_hit)) || fill_mem;
  assign load_data = fill_mem ? mem_rsp_rdata : (hit ? line_data : fwd_data);

  assign wb_push    = st_look;
  assign line_wr    = (st_look && hit) || ld_fwd || fill_mem;
  assign line_inv   = st_look && !hit;
  assign line_wdata = st_look ? req_wdata_q : (fill_mem ? mem_rsp_rdata : fwd_data);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_LOOK;
      ST_LOOK:  state_d = (req_we_q || hit || fwd_hit) ? ST_IDLE : ST_MREQ;
      ST_MREQ:  if (rd_sel && mem_req_ready) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // A write already offered keeps the channel until accepted; otherwise a
  // pending line read goes before draining.
  assign rd_sel        = (state_q == ST_MREQ) && !wr_busy_q;
  assign mem_req_valid = rd_sel || wb_not_empty;
  assign mem_req_we    = !rd_sel;
  assign mem_req_addr  = rd_sel ? req_addr_q : {wb_head_addr, {OFF_W{1'b0}}};
  assign mem_req_wdata = wb_head_data;
  assign wb_pop        = !rd_sel && wb_not_empty && mem_req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      wr_busy_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= load_done;
      wr_busy_q   <= !rd_sel && wb_not_empty && !mem_req_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_we_q    <= cpu_req_we;
      req_addr_q  <= cpu_req_addr;
      req_wdata_q <= cpu_req_wdata;
    end
    if (load_done) rsp_data_q <= load_data;
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

  wt_cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DATA_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (accept),
    .rd_idx   (cpu_req_addr[IDX_W+OFF_W-1:OFF_W]),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_data  (line_data),
    .wr_en    (line_wr),
    .wr_idx   (idx_q),
    .wr_tag   (tag_q),
    .wr_data  (line_wdata),
    .inv_en   (line_inv),
    .inv_idx  (idx_q)
  );

  wt_cache_wbuf #(.AW(WA_W), .DW(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (wb_push),
    .push_addr (word_q),
    .push_data (req_wdata_q),
    .pop       (wb_pop),
    .head_addr (wb_head_addr),
    .head_data (wb_head_data),
    .not_empty (wb_not_empty),
    .full      (wb_full),
    .count     (wb_count),
    .look_addr (word_q),
    .fwd_hit   (fwd_hit),
    .fwd_data  (fwd_data)
  );
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_ready,
  input logic              mem_rsp_valid,
  input logic [CNT_W-1:0]  wb_count,
  input ctl_state_e        state
);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wb_count <= CNT_W'(DEPTH));

  a_r6_write_needs_entry: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> (wb_count != '0));

  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // R3: environment rule, read data only arrives for an outstanding read
  a_r3_rsp_expected: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> (state == ST_MWAIT));

  a_r9_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_rsp_valid && !mem_req_valid && cpu_req_ready));
endmodule

bind wt_cache wt_cache_chk #(.ADDR_W(ADDR_W), .DEPTH(WB_DEPTH), .CNT_W(WB_CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_ready (mem_req_ready),
  .mem_rsp_valid (mem_rsp_valid),
  .wb_count      (wb_count),
  .state         (state_q)
);

// File: tb/wt_cache_tb_top.sv
`timescale 1ns/1ps
module wt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #4 clk = ~clk;

  wt_cache dut_i (.*);

  int checks = 0, fails = 0;
  int reads_seen = 0, rsp_pulses = 0, loads_done = 0;
  bit mem_hold = 1'b0;
  int rd_cnt = -1;
  logic [31:0] rd_hold;
  logic [31:0] mm   [logic [29:0]];
  logic [31:0] arch [logic [29:0]];
  logic [63:0] sq [$];
  bit [1023:0] mv = '0;
  logic [19:0] mt [1024];

  function automatic logic [31:0] init_val(logic [29:0] w);
    return ({2'b00, w} * 32'h0001_9E37) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] mem_rd(logic [29:0] w);
    return mm.exists(w) ? mm[w] : init_val(w);
  endfunction
  function automatic logic [31:0] arch_rd(logic [29:0] w);
    return arch.exists(w) ? arch[w] : init_val(w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // memory model and write-order check (R6), all at the falling edge
  always @(negedge clk) begin
    if (cpu_rsp_valid) rsp_pulses++;
    mem_rsp_valid = 1'b0;
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = rd_hold;
        rd_cnt = -1;
      end
    end
    mem_req_ready = !mem_hold && ($urandom_range(0, 3) != 0);
    if (!rst && mem_req_valid) begin
      if (!mem_req_we) reads_seen++;
      if (mem_req_ready) begin
        if (mem_req_we) begin
          logic [63:0] e;
          if (sq.size() == 0) begin
            checks++; fails++;
            $display("FAIL R6 unexpected write actual=%h expected=none", mem_req_addr);
          end else begin
            e = sq.pop_front();
            chk("R6 write addr", mem_req_addr, e[63:32]);
            chk("R6 write data", mem_req_wdata, e[31:0]);
          end
          mm[mem_req_addr[31:2]] = mem_req_wdata;
        end else begin
          rd_hold = mem_rd(mem_req_addr[31:2]);
          rd_cnt = 3;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rdata, output int lat,
                        output int rd_delta, output bit pred_hit);
    int r0;
    logic [9:0]  ix = a[11:2];
    logic [19:0] tg = a[31:12];
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    pred_hit = mv[ix] && (mt[ix] == tg);
    r0 = reads_seen;
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d;
    if (we) begin
      sq.push_back({a[31:2], 2'b00, d});
      arch[a[31:2]] = d;
      if (!pred_hit) mv[ix] = 1'b0;
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 1;
    rdata = '0;
    if (!we) begin
      while (!cpu_rsp_valid && lat < 500) begin
        @(negedge clk);
        lat++;
      end
      rdata = cpu_rsp_rdata;
      loads_done++;
      mv[ix] = 1'b1; mt[ix] = tg;
    end
    rd_delta = reads_seen - r0;
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((sq.size() != 0 || mem_req_valid) && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ld(input logic [31:0] a, output logic [31:0] v, output int lat,
                    output int rdd, output bit ph);
    access(1'b0, a, 32'h0, v, lat, rdd, ph);
  endtask
  task automatic st(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] v; int lat, rdd; bit ph;
    access(1'b1, a, d, v, lat, rdd, ph);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v; int lat, rdd; bit ph;
    logic [31:0] A, B, C, X;
    A = 32'h0000_0100; B = A + 32'h1000; C = A + 32'h4; X = 32'h0000_03F0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 ready after reset", {31'b0, cpu_req_ready}, 32'd1);
    chk("R9 no mem req after reset", {31'b0, mem_req_valid}, 32'd0);
    chk("R9 no rsp after reset", {31'b0, cpu_rsp_valid}, 32'd0);

    // R9 / R3 first load misses and fetches
    ld(A, v, lat, rdd, ph);
    chk("R9 first load reads memory", {31'b0, rdd > 0}, 32'd1);
    chk("R3 miss data", v, init_val(A[31:2]));
    // R2 hit
    ld(A, v, lat, rdd, ph);
    chk("R2 hit latency", lat, 2);
    chk("R2 hit no read", rdd, 0);
    chk("R3 filled data", v, init_val(A[31:2]));
    // R4 store hit
    st(A, 32'hD1D1_0001);
    ld(A, v, lat, rdd, ph);
    chk("R4 load after store hit latency", lat, 2);
    chk("R4 load after store hit data", v, 32'hD1D1_0001);
    // R1 index and tag split
    wait_drain();
    ld(B, v, lat, rdd, ph);
    chk("R1 same index other tag misses", {31'b0, rdd > 0}, 32'd1);
    chk("R1 data", v, init_val(B[31:2]));
    ld(A, v, lat, rdd, ph);
    chk("R1 evicted line misses", {31'b0, rdd > 0}, 32'd1);
    chk("R1 evicted line data", v, 32'hD1D1_0001);
    ld(C, v, lat, rdd, ph);
    ld(A, v, lat, rdd, ph);
    chk("R1 other index keeps line", lat, 2);
    // R5 store miss invalidates
    st(B, 32'hD2D2_0002);
    wait_drain();
    ld(A, v, lat, rdd, ph);
    chk("R5 line invalid after store miss", {31'b0, rdd > 0}, 32'd1);
    chk("R5 data", v, 32'hD1D1_0001);
    ld(B, v, lat, rdd, ph);
    chk("R5 stored word reached memory", v, 32'hD2D2_0002);

    // R8 forwarding with memory held off, R7 full stall
    wait_drain();
    mem_hold = 1'b1;
    st(X, 32'h0000_0011);
    st(X, 32'h0000_0022);
    ld(X, v, lat, rdd, ph);
    chk("R8 youngest forward data", v, 32'h0000_0022);
    chk("R8 no memory read", rdd, 0);
    chk("R8 latency", lat, 2);
    ld(X, v, lat, rdd, ph);
    chk("R8 forwarded word installed", lat, 2);
    st(32'h0000_0800, 32'h0000_0033);
    st(32'h0000_0804, 32'h0000_0044);
    repeat (3) @(negedge clk);
    chk("R7 ready low when full", {31'b0, cpu_req_ready}, 32'd0);
    mem_hold = 1'b0;
    begin
      int n = 0;
      while (!cpu_req_ready && n < 50) begin @(negedge clk); n++; end
    end
    chk("R7 ready returns after drain", {31'b0, cpu_req_ready}, 32'd1);
    wait_drain();
    chk("R6 last store wins in memory", mem_rd(X[31:2]), 32'h0000_0022);

    // mixed pseudo-random traffic over two indices and three tags
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = {10'b0, 2'(($urandom_range(0, 2))), 10'd0, 8'h0} |
          ({$urandom_range(0, 2), 12'h000}) | ({20'b0, 8'h0, 2'($urandom_range(0,1)), 2'b00} << 0);
      a = {12'b0, 8'(a[13:12] % 3), 10'd5 + 10'(a[2]), 2'b00};
      if ($urandom_range(0, 2) == 0) begin
        st(a, $urandom());
      end else begin
        ld(a, v, lat, rdd, ph);
        chk("R3 load value", v, arch_rd(a[31:2]));
        if (ph) chk("R2 predicted hit latency", lat, 2);
      end
    end
    wait_drain();
    chk("R6 all stores drained", sq.size(), 0);
    repeat (2) @(negedge clk);
    chk("R2 one response per load", rsp_pulses, loads_done);
    summary();
    $finish;
  end
endmodule